// File: doc/BRIEF.md
# Dual-Stream Bipolar Line Codec

This block lets two synchronous serial bit streams share one three-level line without a faster clock. Each bit period is split into two halves. In the first half the upper stream's bit is sent as a positive pulse. In the second half the lower stream's bit is sent as a negative pulse. The line level is modelled digitally as a 2-bit symbol. Zero is `2'b00`, positive is `2'b01` and negative is `2'b10`. The code `2'b11` is never legal on the line.

The clock runs at twice the bit rate, and each clock cycle is one half of a bit period. The transmitter is given a phase input, `tx_phase`, which is low in the cycle that presents a new bit pair. The receiver is given its own phase input, `rx_phase`, which is low while the line carries a positive slot and high while it carries a negative slot. The receiver samples each slot at the clock edge that closes it. After the negative slot it presents both recovered bits together with a one-cycle strobe. It also keeps two sticky error flags: one for a pulse of the wrong polarity in a slot, and one for the illegal code. The parameter `LANES` gives that many independent transmit and receive channels, which share the two phase inputs. All lanes share one common clock.

Top module: `bipolar_line_codec`

## Requirements
- R1: The transmitter emits only the codes zero `2'b00`, positive `2'b01` and negative `2'b10` on each lane's 2-bit field `line_tx[2*i+1:2*i]`. It never emits `2'b11`.
- R2: At a clock edge where `tx_phase` is 0, both stream inputs of every lane are captured. Through the following cycle (the positive slot) the lane shows positive if `tx_upper` was 1, and zero otherwise.
- R3: The lower stream input `tx_lower_n` is active low. In the cycle after an edge where `tx_phase` is 1 (the negative slot), the lane shows negative if the captured `tx_lower_n` was 0, and zero if it was 1.
- R4: The stream inputs are ignored at edges where `tx_phase` is 1. Changing them there alters neither the negative slot in progress nor the following positive slot.
- R5: The receiver samples the positive slot at an edge with `rx_phase` 0 and the negative slot at an edge with `rx_phase` 1. After the negative-slot edge it raises `rx_valid` for exactly one cycle. This happens only when a positive-slot sample came immediately before.
- R6: With `rx_valid`, `rx_upper` is 1 when the positive slot held positive. `rx_lower_n` is 0 when the negative slot held negative (active low, matching the transmit input). Both outputs hold their values until the next strobe.
- R7: A negative code in a positive slot, or a positive code in a negative slot, sets `rx_proto_err`. The flag stays set until reset.
- R8: The code `2'b11` on any receive lane, in either slot, sets `rx_line_err`, which stays set until reset. That code does not set `rx_proto_err` and is read as no pulse.
- R9: While `rst_n` is low, `line_tx` is all zero, `rx_valid`, `rx_upper`, `rx_proto_err` and `rx_line_err` are 0, and `rx_lower_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock, one cycle per slot |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_phase | input | 1 | 0 at the edge that loads a new bit pair, 1 at the edge that opens the negative slot |
| tx_upper | input | LANES | Upper stream bit per lane, active high |
| tx_lower_n | input | LANES | Lower stream bit per lane, active low |
| line_tx | output | 2*LANES | Transmitted line symbol per lane |
| rx_phase | input | 1 | 0 while the received line carries a positive slot, 1 for a negative slot |
| line_rx | input | 2*LANES | Received line symbol per lane |
| rx_upper | output | LANES | Recovered upper stream bit |
| rx_lower_n | output | LANES | Recovered lower stream bit, active low |
| rx_valid | output | 1 | One-cycle strobe for a recovered pair |
| rx_proto_err | output | 1 | Sticky wrong-polarity flag |
| rx_line_err | output | 1 | Sticky illegal-code flag |

## Verification
The hardest situations to reach are a pulse of the wrong polarity and the illegal code. A loopback of the transmitter can never produce either one. The bench therefore places an override multiplexer in front of `line_rx`. That multiplexer forces a chosen code for exactly one slot, aligned to `rx_phase`, and the flags are then checked in the next cycle. The ignored-input case is reached by presenting inverted data during the second-half cycle of every bit period, so that a design that sampled the inputs late would emit the wrong slots.

// File: rtl/bpl_pkg.sv
// Package: shared line symbol encoding for the bipolar codec.
// Assumes a 2-bit digital model of a three-level line.
package bpl_pkg;
    typedef enum logic [1:0] {
        SYM_ZERO = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10,
        SYM_BAD  = 2'b11
    } line_sym_e;
endpackage

// File: rtl/bpl_tx_lane.sv
// Transmit lane: turns one upper and one active-low lower bit into a
// positive slot followed by a negative slot.
// Assumes tx_phase alternates 0,1 each cycle; the inputs are sampled only
// when tx_phase is 0.
module bpl_tx_lane
    import bpl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_phase,
    input  logic      up_bit,
    input  logic      lo_bit_n,
    output line_sym_e sym
);
    logic lo_hold_n;
    logic neg_gate_n;

    // Lower data is ORed with the inverted phase, so it is low only in the second half.
    always_comb neg_gate_n = lo_hold_n | ~tx_phase;

    // Capture the pair at the first half and drive the slot symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym       <= SYM_ZERO;
            lo_hold_n <= 1'b1;
        end else if (!tx_phase) begin
            sym       <= up_bit ? SYM_POS : SYM_ZERO;
            lo_hold_n <= lo_bit_n;
        end else begin
            sym       <= neg_gate_n ? SYM_ZERO : SYM_NEG;
        end
    end
endmodule

// File: rtl/bpl_rx_lane.sv
// Receive lane: samples the positive slot and then the negative slot, and
// presents the recovered pair with a one-cycle strobe.
// Assumes rx_phase is aligned to the slot currently on the line.
module bpl_rx_lane
    import bpl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_phase,
    input  line_sym_e sym,
    output logic      up_q,
    output logic      lo_n_q,
    output logic      valid_q,
    output logic      proto_hit,
    output logic      bad_hit
);
    logic pos_q;
    logic have_pos;

    // Flag wrong polarity for the current slot and the illegal code.
    always_comb begin
        proto_hit = (!rx_phase && sym == SYM_NEG) || (rx_phase && sym == SYM_POS);
        bad_hit   = (sym == SYM_BAD);
    end

    // Slice the two slots and emit a pair after the negative slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= 1'b0;
            have_pos <= 1'b0;
            up_q     <= 1'b0;
            lo_n_q   <= 1'b1;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (!rx_phase) begin
                pos_q    <= (sym == SYM_POS);
                have_pos <= 1'b1;
            end else begin
                if (have_pos) begin
                    up_q    <= pos_q;
                    lo_n_q  <= (sym != SYM_NEG);
                    valid_q <= 1'b1;
                end
                have_pos <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bpl_err_track.sv
// Error tracker: gathers per-lane error hits into two sticky flags.
// Assumes hits are combinational per cycle; flags clear only on reset.
module bpl_err_track #(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] proto_hits,
    input  logic [LANES-1:0] bad_hits,
    output logic             proto_err,
    output logic             line_err
);
    // Set-only flags for the two error classes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
            line_err  <= 1'b0;
        end else begin
            proto_err <= proto_err | (|proto_hits);
            line_err  <= line_err  | (|bad_hits);
        end
    end
endmodule

// File: rtl/bipolar_line_codec.sv
// Top: LANES transmit and receive bipolar lanes sharing the phase inputs,
// plus sticky error tracking.
// Assumes one common clock at twice the bit rate.
module bipolar_line_codec
    import bpl_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_phase,
    input  logic [LANES-1:0]   tx_upper,
    input  logic [LANES-1:0]   tx_lower_n,
    output logic [2*LANES-1:0] line_tx,
    input  logic               rx_phase,
    input  logic [2*LANES-1:0] line_rx,
    output logic [LANES-1:0]   rx_upper,
    output logic [LANES-1:0]   rx_lower_n,
    output logic               rx_valid,
    output logic               rx_proto_err,
    output logic               rx_line_err
);
    localparam int SYM_W = 2;

    logic [LANES-1:0] proto_hits;
    logic [LANES-1:0] bad_hits;
    logic [LANES-1:0] valid_v;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        line_sym_e tx_sym;
        line_sym_e rx_sym;

        // Cast the received bits of this lane to the symbol type.
        always_comb rx_sym = line_sym_e'(line_rx[g*SYM_W +: SYM_W]);
        // Drive this lane's transmitted bits.
        always_comb line_tx[g*SYM_W +: SYM_W] = tx_sym;

        bpl_tx_lane u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_phase (tx_phase),
            .up_bit   (tx_upper[g]),
            .lo_bit_n (tx_lower_n[g]),
            .sym      (tx_sym)
        );

        bpl_rx_lane u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .rx_phase  (rx_phase),
            .sym       (rx_sym),
            .up_q      (rx_upper[g]),
            .lo_n_q    (rx_lower_n[g]),
            .valid_q   (valid_v[g]),
            .proto_hit (proto_hits[g]),
            .bad_hit   (bad_hits[g])
        );
    end

    // All lanes share the phase, so their strobes coincide; lane 0 speaks for all.
    always_comb rx_valid = valid_v[0];

    bpl_err_track #(.LANES(LANES)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .proto_hits (proto_hits),
        .bad_hits   (bad_hits),
        .proto_err  (rx_proto_err),
        .line_err   (rx_line_err)
    );
endmodule

// File: rtl/bipolar_line_codec_chk.sv
// Checker: temporal properties of the codec ports, bound to the top.
module bipolar_line_codec_chk #(
    parameter int LANES = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_phase,
    input logic [LANES-1:0]   tx_upper,
    input logic [2*LANES-1:0] line_tx,
    input logic [2*LANES-1:0] line_rx,
    input logic               rx_valid,
    input logic               rx_proto_err,
    input logic               rx_line_err
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_no_bad_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
            line_tx[2*g +: 2] != 2'b11);
        assert_pos_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_phase |=> (line_tx[2*g +: 2] != 2'b10) &&
                          ((line_tx[2*g +: 2] == 2'b01) == $past(tx_upper[g])));
        assert_neg_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tx_phase |=> line_tx[2*g +: 2] != 2'b01);
        assert_bad_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (line_rx[2*g +: 2] == 2'b11) |=> rx_line_err);
    end

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_proto_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_proto_err |=> rx_proto_err);
    assert_line_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_line_err |=> rx_line_err);
endmodule

bind bipolar_line_codec bipolar_line_codec_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_phase     (tx_phase),
    .tx_upper     (tx_upper),
    .line_tx      (line_tx),
    .line_rx      (line_rx),
    .rx_valid     (rx_valid),
    .rx_proto_err (rx_proto_err),
    .rx_line_err  (rx_line_err)
);

// File: tb/bipolar_line_codec_tb_top.sv
// Scoreboard bench: the driver pushes expected pairs, the monitor pops them
// when the receiver strobes. The line loops back unless a code is injected.
module bipolar_line_codec_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_phase = 1'b0;
    logic [0:0] tx_upper = 1'b0;
    logic [0:0] tx_lower_n = 1'b1;
    logic [1:0] line_tx;
    logic       rx_phase = 1'b1;
    logic [1:0] line_rx;
    logic [0:0] rx_upper;
    logic [0:0] rx_lower_n;
    logic       rx_valid;
    logic       rx_proto_err;
    logic       rx_line_err;

    logic       inj_en = 1'b0;
    logic [1:0] inj_val = 2'b00;
    logic       mon_en = 1'b0;
    int         n_checks = 0;
    int         n_fail = 0;
    logic [1:0] exp_q[$];
    logic       have_last = 1'b0;
    logic [1:0] last_pair = 2'b00;

    always #10 clk = ~clk;

    // Loopback with an override for fault injection.
    always_comb line_rx = inj_en ? inj_val : line_tx;

    bipolar_line_codec dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_phase     (tx_phase),
        .tx_upper     (tx_upper),
        .tx_lower_n   (tx_lower_n),
        .line_tx      (line_tx),
        .rx_phase     (rx_phase),
        .line_rx      (line_rx),
        .rx_upper     (rx_upper),
        .rx_lower_n   (rx_lower_n),
        .rx_valid     (rx_valid),
        .rx_proto_err (rx_proto_err),
        .rx_line_err  (rx_line_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: send one bit pair over two cycles; optionally disturb inputs in the second half.
    task automatic send_pair(input bit up, input bit lo_n, input bit disturb);
        tx_phase   = 1'b0;
        rx_phase   = 1'b1;
        tx_upper   = up;
        tx_lower_n = lo_n;
        exp_q.push_back({up, lo_n});
        @(negedge clk);
        check(line_tx == (up ? 2'b01 : 2'b00), "R2 pos slot (R1 code)", line_tx, up ? 1 : 0);
        tx_phase = 1'b1;
        rx_phase = 1'b0;
        if (disturb) begin
            tx_upper   = ~up;
            tx_lower_n = ~lo_n;
        end
        @(negedge clk);
        check(line_tx == (lo_n ? 2'b00 : 2'b10), "R3/R4 neg slot (R1 code)", line_tx, lo_n ? 0 : 2);
    endtask

    // Monitor: compare strobed pairs with the queue; outputs must hold between strobes (R6).
    always @(negedge clk) begin
        if (mon_en && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected strobe", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check({rx_upper[0], rx_lower_n[0]} == e, "R5/R6 recovered pair",
                      {rx_upper[0], rx_lower_n[0]}, e);
                last_pair = e;
                have_last = 1'b1;
            end
        end else if (mon_en && have_last) begin
            check({rx_upper[0], rx_lower_n[0]} == last_pair, "R6 hold between strobes",
                  {rx_upper[0], rx_lower_n[0]}, last_pair);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_tx == 2'b00, "R9 reset line", line_tx, 0);
        check(rx_valid == 1'b0 && rx_upper[0] == 1'b0, "R9 reset rx", rx_valid, 0);
        check(rx_lower_n[0] == 1'b1, "R9 reset lower_n", rx_lower_n[0], 1);
        check(!rx_proto_err && !rx_line_err, "R9 reset flags", rx_proto_err, 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        // All four pair patterns, then ignored-input disturbance (R4).
        send_pair(1'b1, 1'b0, 1'b0);
        send_pair(1'b0, 1'b1, 1'b0);
        send_pair(1'b1, 1'b1, 1'b0);
        send_pair(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            send_pair(i[0] ^ i[2], i[1], 1'b1);
        end
        send_pair(1'b0, 1'b1, 1'b0);
        send_pair(1'b0, 1'b1, 1'b0);
        check(exp_q.size() <= 1, "R5 all pairs strobed", exp_q.size(), 1);
        check(!rx_proto_err && !rx_line_err, "R7/R8 clean run no flags", rx_proto_err, 0);
        mon_en = 1'b0;
        exp_q.delete();
        // Illegal code in a negative slot: line error only, read as no pulse (R8).
        tx_phase = 1'b0; rx_phase = 1'b1; tx_upper = 1'b0; tx_lower_n = 1'b1;
        @(negedge clk);
        tx_phase = 1'b1; rx_phase = 1'b0;
        @(negedge clk);
        tx_phase = 1'b0; rx_phase = 1'b1; inj_en = 1'b1; inj_val = 2'b11;
        @(negedge clk);
        inj_en = 1'b0;
        check(rx_line_err == 1'b1, "R8 line err set", rx_line_err, 1);
        check(rx_proto_err == 1'b0, "R8 no proto err", rx_proto_err, 0);
        check(rx_valid && rx_lower_n[0] == 1'b1, "R8 bad read as no pulse", rx_lower_n[0], 1);
        // Negative code in a positive slot (R7).
        tx_phase = 1'b1; rx_phase = 1'b0; inj_en = 1'b1; inj_val = 2'b10;
        @(negedge clk);
        inj_en = 1'b0;
        check(rx_proto_err == 1'b1, "R7 proto err set", rx_proto_err, 1);
        for (int i = 0; i < 4; i++) begin
            tx_phase = 1'b0; rx_phase = 1'b1;
            @(negedge clk);
            tx_phase = 1'b1; rx_phase = 1'b0;
            @(negedge clk);
        end
        check(rx_proto_err == 1'b1, "R7 proto err sticky", rx_proto_err, 1);
        check(rx_line_err == 1'b1, "R8 line err sticky", rx_line_err, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule